// File: doc/BRIEF.md
# USB Endpoint Packet Buffer Channels

This block connects a USB serial interface engine (SIE), a CPU and one single-port, byte-wide packet SRAM. It has one channel for each endpoint. The SIE picks the channel whose index equals the endpoint number of the current transaction.

Each channel holds a read base address, a write base address, a receive byte limit, a prefetched data byte with a valid flag, and a received-byte count.

For transmission towards the host, software writes the read base. That write starts an SRAM fetch at once. After that, each byte the SIE takes, at byte count k, starts a fetch of the byte at read base + k + 1. The next byte is therefore waiting before the SIE asks for it.

For reception, the SIE presents each byte with its byte count. The byte is stored at write base + count while the count is below the limit. Every byte still updates the received count, including bytes past the limit.

The CPU fills and drains the SRAM through a request/grant port. Requests from the SIE always win the SRAM, so the CPU only gets a cycle the SIE does not need.

Top module: `usb_ep_bufmem`

## Requirements
- R1: After reset every channel's valid flag is 0, its data byte is 0 and its received count is 0.
- R2: A register write with cpu_reg_sel = 0 loads the read base of channel cpu_reg_ch. It clears that channel's valid flag in the next cycle. Within BYTE_CLKS cycles the flag returns to 1, with the SRAM byte at the new base in the data register.
- R3: A take by the SIE at byte count k clears the channel's valid flag. The flag later returns with the byte at (read base + k + 1) mod 2^AW.
- R4: sie_rdata and sie_rvalid show the channel selected by sie_ch. Channels keep their bases, data and counts independently of one another.
- R5: A received byte at count c, where c is below the channel's limit, is written to SRAM address (write base + c) mod 2^AW. cpu_reg_sel = 1 writes the write base and cpu_reg_sel = 2 writes the limit.
- R6: A received byte at count c, where c is at or above the limit, leaves the SRAM unchanged. The channel's received count still becomes c + 1.
- R7: The received count saturates at 2^CNTW - 1 and never wraps to 0.
- R8: A resent packet restarts its count at 0 and overwrites the bytes the earlier attempt stored. The received count then follows the new count.
- R9: SRAM priority runs from SIE writes, to prefetches (lowest channel first), to the CPU. cpu_mem_gnt is 0 in any cycle with an SIE write or a pending prefetch.
- R10: A granted CPU write stores cpu_mem_wdata at cpu_mem_addr. A granted CPU read returns its byte on cpu_mem_rdata with cpu_mem_rvalid in the cycle after the grant.
- R11: If the read base is rewritten while an earlier fetch is pending or in flight, the data register ends up with the byte at the last base written.
- R12: The SIE takes a byte only while sie_rvalid is 1. This is a rule on the SIE that the block checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_reg_wr | input | 1 | Channel register write strobe |
| cpu_reg_sel | input | 2 | 0 read base, 1 write base, 2 limit |
| cpu_reg_ch | input | CHW | Channel for register write and count readback |
| cpu_reg_data | input | CNTW | Register write data (bases use the low AW bits) |
| cpu_rx_cnt | output | CNTW | Received count of channel cpu_reg_ch |
| cpu_mem_req | input | 1 | CPU SRAM access request |
| cpu_mem_we | input | 1 | CPU access is a write |
| cpu_mem_addr | input | AW | CPU SRAM address |
| cpu_mem_wdata | input | DW | CPU write data |
| cpu_mem_gnt | output | 1 | CPU access performed this cycle |
| cpu_mem_rvalid | output | 1 | CPU read data valid |
| cpu_mem_rdata | output | DW | CPU read data |
| sie_ch | input | CHW | Endpoint channel of the current transaction |
| sie_cnt | input | CNTW | SIE byte counter |
| sie_in_take | input | 1 | SIE takes the prefetched byte |
| sie_out_wr | input | 1 | SIE presents a received byte |
| sie_out_data | input | DW | Received byte |
| sie_rdata | output | DW | Prefetched byte of channel sie_ch |
| sie_rvalid | output | 1 | Prefetched byte of channel sie_ch is valid |

## Verification
Several properties are checked on every cycle:
- a base write or a take always clears the valid flag and leaves a fetch pending;
- no fetch stays pending as long as BYTE_CLKS cycles;
- the CPU is never granted alongside an SIE write;
- a received byte at or past the limit never writes the SRAM;
- the received count never wraps to zero;
- the SIE never takes an invalid byte.

Only the bench's scenarios can show that the right bytes arrive. These cover address wrap at the top of the SRAM, prefetch of the last-written base after back-to-back writes, and overwrite on a resent packet. They also cover the exact stored contents around the limit and saturation of the count. The bench compares against its own memory model.

// File: rtl/usbpm_pkg.sv
package usbpm_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SIE   = 2'd1,
    SRC_FETCH = 2'd2,
    SRC_CPU   = 2'd3
  } src_e;

  localparam logic [1:0] SEL_RDBASE = 2'd0;
  localparam logic [1:0] SEL_WRBASE = 2'd1;
  localparam logic [1:0] SEL_LIMIT  = 2'd2;
endpackage

// File: rtl/usbpm_sram.sv
module usbpm_sram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end else if (re) begin
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/usbpm_chan.sv
module usbpm_chan #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int CNTW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_rd,
  input  logic            set_wr,
  input  logic            set_lim,
  input  logic [CNTW-1:0] reg_data,
  input  logic            take,
  input  logic            rx_wr,
  input  logic [CNTW-1:0] sie_cnt,
  input  logic            issued,
  input  logic            load,
  input  logic [DW-1:0]   load_data,
  output logic            restart,
  output logic            pend,
  output logic [AW-1:0]   fetch_addr,
  output logic [DW-1:0]   data,
  output logic            valid,
  output logic [AW-1:0]   wr_base,
  output logic [CNTW-1:0] limit,
  output logic [CNTW-1:0] rx_cnt
);
  localparam logic [AW-1:0]   ONE_A = AW'(1);
  localparam logic [CNTW-1:0] CMAX  = {CNTW{1'b1}};

  logic [AW-1:0] rd_base;

  assign restart = set_rd | take;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_base    <= '0;
      fetch_addr <= '0;
      wr_base    <= '0;
      limit      <= '0;
      pend       <= 1'b0;
      valid      <= 1'b0;
      data       <= '0;
      rx_cnt     <= '0;
    end else begin
      if (set_rd) begin
        rd_base    <= reg_data[AW-1:0];
        fetch_addr <= reg_data[AW-1:0];
      end else if (take) begin
        fetch_addr <= rd_base + sie_cnt[AW-1:0] + ONE_A;
      end
      if (set_wr)  wr_base <= reg_data[AW-1:0];
      if (set_lim) limit   <= reg_data;

      if (restart)     pend <= 1'b1;
      else if (issued) pend <= 1'b0;

      if (restart) begin
        valid <= 1'b0;
      end else if (load) begin
        valid <= 1'b1;
        data  <= load_data;
      end

      if (rx_wr) rx_cnt <= (sie_cnt == CMAX) ? CMAX : sie_cnt + 1'b1;
    end
  end

  p_base_clears_valid_r2: assert property (@(posedge clk) disable iff (rst)
    set_rd |=> (!valid && pend));
  p_take_refetch_r3: assert property (@(posedge clk) disable iff (rst)
    take |=> (pend && !valid));
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    rx_wr |=> (rx_cnt != '0));
endmodule

// File: rtl/usbpm_arb.sv
module usbpm_arb
  import usbpm_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int BYTE_CLKS = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sie_wr_req,
  input  logic [NCH-1:0] pend,
  input  logic           cpu_req,
  output src_e           src,
  output logic [(NCH>1?$clog2(NCH):1)-1:0] fetch_ch,
  output logic [NCH-1:0] issue
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int AGW = $clog2(BYTE_CLKS + 1);

  always_comb begin
    src      = SRC_NONE;
    fetch_ch = '0;
    issue    = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) fetch_ch = CHW'(i);
    end
    if (sie_wr_req) begin
      src = SRC_SIE;
    end else if (|pend) begin
      src             = SRC_FETCH;
      issue[fetch_ch] = 1'b1;
    end else if (cpu_req) begin
      src = SRC_CPU;
    end
  end

  p_one_issue_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue));

  // per-channel wait counters: a fetch never waits a full byte time (R2)
  for (genvar g = 0; g < NCH; g++) begin : g_age
    logic [AGW-1:0] age;
    always_ff @(posedge clk) begin
      if (rst || !pend[g])              age <= '0;
      else if (age != AGW'(BYTE_CLKS))  age <= age + 1'b1;
    end
    p_fetch_deadline_r2: assert property (@(posedge clk) disable iff (rst)
      age < AGW'(BYTE_CLKS));
  end
endmodule

// File: rtl/usb_ep_bufmem.sv
module usb_ep_bufmem
  import usbpm_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int CNTW      = 10,
  parameter int BYTE_CLKS = 32,
  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_reg_wr,
  input  logic [1:0]      cpu_reg_sel,
  input  logic [CHW-1:0]  cpu_reg_ch,
  input  logic [CNTW-1:0] cpu_reg_data,
  output logic [CNTW-1:0] cpu_rx_cnt,
  input  logic            cpu_mem_req,
  input  logic            cpu_mem_we,
  input  logic [AW-1:0]   cpu_mem_addr,
  input  logic [DW-1:0]   cpu_mem_wdata,
  output logic            cpu_mem_gnt,
  output logic            cpu_mem_rvalid,
  output logic [DW-1:0]   cpu_mem_rdata,
  input  logic [CHW-1:0]  sie_ch,
  input  logic [CNTW-1:0] sie_cnt,
  input  logic            sie_in_take,
  input  logic            sie_out_wr,
  input  logic [DW-1:0]   sie_out_data,
  output logic [DW-1:0]   sie_rdata,
  output logic            sie_rvalid
);
  logic [NCH-1:0] restart, pend, valid, issue, load;
  logic [AW-1:0]   fetch_addr_a [NCH];
  logic [AW-1:0]   wr_base_a    [NCH];
  logic [DW-1:0]   data_a       [NCH];
  logic [CNTW-1:0] limit_a      [NCH];
  logic [CNTW-1:0] rx_cnt_a     [NCH];

  src_e           src;
  logic [CHW-1:0] fetch_ch;
  logic [CNTW-1:0] lim_sel;
  logic           out_ok;
  logic           ram_we, ram_re;
  logic [AW-1:0]  ram_addr;
  logic [DW-1:0]  ram_wdata, ram_rdata;

  logic           fl_fetch, fl_cpu, fl_kill;
  logic [CHW-1:0] fl_ch;

  assign lim_sel = limit_a[sie_ch];
  assign out_ok  = sie_out_wr && (sie_cnt < lim_sel);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit_reg, hit_sie;
    assign hit_reg = cpu_reg_wr && (cpu_reg_ch == CHW'(g));
    assign hit_sie = (sie_ch == CHW'(g));
    assign load[g] = fl_fetch && (fl_ch == CHW'(g)) && !fl_kill && !restart[g];

    usbpm_chan #(.AW(AW), .DW(DW), .CNTW(CNTW)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .set_rd     (hit_reg && cpu_reg_sel == SEL_RDBASE),
      .set_wr     (hit_reg && cpu_reg_sel == SEL_WRBASE),
      .set_lim    (hit_reg && cpu_reg_sel == SEL_LIMIT),
      .reg_data   (cpu_reg_data),
      .take       (hit_sie && sie_in_take),
      .rx_wr      (hit_sie && sie_out_wr),
      .sie_cnt    (sie_cnt),
      .issued     (issue[g]),
      .load       (load[g]),
      .load_data  (ram_rdata),
      .restart    (restart[g]),
      .pend       (pend[g]),
      .fetch_addr (fetch_addr_a[g]),
      .data       (data_a[g]),
      .valid      (valid[g]),
      .wr_base    (wr_base_a[g]),
      .limit      (limit_a[g]),
      .rx_cnt     (rx_cnt_a[g])
    );
  end

  usbpm_arb #(.NCH(NCH), .BYTE_CLKS(BYTE_CLKS)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .sie_wr_req (out_ok),
    .pend       (pend),
    .cpu_req    (cpu_mem_req),
    .src        (src),
    .fetch_ch   (fetch_ch),
    .issue      (issue)
  );

  always_comb begin
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_addr  = cpu_mem_addr;
    ram_wdata = cpu_mem_wdata;
    unique case (src)
      SRC_SIE: begin
        ram_we    = 1'b1;
        ram_addr  = wr_base_a[sie_ch] + sie_cnt[AW-1:0];
        ram_wdata = sie_out_data;
      end
      SRC_FETCH: begin
        ram_re   = 1'b1;
        ram_addr = fetch_addr_a[fetch_ch];
      end
      SRC_CPU: begin
        ram_we = cpu_mem_we;
        ram_re = !cpu_mem_we;
      end
      default: ;
    endcase
  end

  usbpm_sram #(.AW(AW), .DW(DW)) u_sram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  // track the read in flight; a restart of its channel discards the result
  always_ff @(posedge clk) begin
    if (rst) begin
      fl_fetch <= 1'b0;
      fl_cpu   <= 1'b0;
      fl_kill  <= 1'b0;
      fl_ch    <= '0;
    end else begin
      fl_fetch <= (src == SRC_FETCH);
      fl_cpu   <= (src == SRC_CPU) && !cpu_mem_we;
      fl_kill  <= restart[fetch_ch];
      fl_ch    <= fetch_ch;
    end
  end

  assign cpu_mem_gnt    = (src == SRC_CPU);
  assign cpu_mem_rvalid = fl_cpu;
  assign cpu_mem_rdata  = ram_rdata;
  assign cpu_rx_cnt     = rx_cnt_a[cpu_reg_ch];
  assign sie_rdata      = data_a[sie_ch];
  assign sie_rvalid     = valid[sie_ch];

  p_take_valid_r12: assert property (@(posedge clk) disable iff (rst)
    sie_in_take |-> sie_rvalid);
  p_cpu_yield_r9: assert property (@(posedge clk) disable iff (rst)
    (out_ok || (|pend)) |-> !cpu_mem_gnt);
  p_cpu_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_mem_gnt && !cpu_mem_we) |=> cpu_mem_rvalid);
  p_limit_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (sie_out_wr && sie_cnt >= lim_sel) |-> !ram_we);
endmodule

// File: tb/usb_ep_bufmem_tb.sv
`timescale 1ns/1ps
module usb_ep_bufmem_tb;
  localparam int NCH = 4, AW = 8, DW = 8, CNTW = 10, BYTE_CLKS = 32;
  localparam int CHW = 2;
  localparam int CMAX = (1 << CNTW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_reg_wr = 0;
  logic [1:0] cpu_reg_sel = 0;
  logic [CHW-1:0] cpu_reg_ch = 0;
  logic [CNTW-1:0] cpu_reg_data = 0;
  logic [CNTW-1:0] cpu_rx_cnt;
  logic cpu_mem_req = 0, cpu_mem_we = 0;
  logic [AW-1:0] cpu_mem_addr = 0;
  logic [DW-1:0] cpu_mem_wdata = 0;
  logic cpu_mem_gnt, cpu_mem_rvalid;
  logic [DW-1:0] cpu_mem_rdata;
  logic [CHW-1:0] sie_ch = 0;
  logic [CNTW-1:0] sie_cnt = 0;
  logic sie_in_take = 0, sie_out_wr = 0;
  logic [DW-1:0] sie_out_data = 0;
  logic [DW-1:0] sie_rdata;
  logic sie_rvalid;

  int n_chk = 0, n_bad = 0;
  int ref_mem [256];

  always #2.5 clk = ~clk;

  usb_ep_bufmem #(.NCH(NCH), .AW(AW), .DW(DW), .CNTW(CNTW), .BYTE_CLKS(BYTE_CLKS)) u_dut (
    .clk(clk), .rst(rst),
    .cpu_reg_wr(cpu_reg_wr), .cpu_reg_sel(cpu_reg_sel), .cpu_reg_ch(cpu_reg_ch),
    .cpu_reg_data(cpu_reg_data), .cpu_rx_cnt(cpu_rx_cnt),
    .cpu_mem_req(cpu_mem_req), .cpu_mem_we(cpu_mem_we), .cpu_mem_addr(cpu_mem_addr),
    .cpu_mem_wdata(cpu_mem_wdata), .cpu_mem_gnt(cpu_mem_gnt),
    .cpu_mem_rvalid(cpu_mem_rvalid), .cpu_mem_rdata(cpu_mem_rdata),
    .sie_ch(sie_ch), .sie_cnt(sie_cnt), .sie_in_take(sie_in_take),
    .sie_out_wr(sie_out_wr), .sie_out_data(sie_out_data),
    .sie_rdata(sie_rdata), .sie_rvalid(sie_rvalid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat_inc(input int c);
    return (c >= CMAX) ? CMAX : c + 1;
  endfunction

  task automatic reg_write(input int sel, input int ch, input int d);
    @(negedge clk);
    cpu_reg_wr = 1; cpu_reg_sel = 2'(sel); cpu_reg_ch = CHW'(ch); cpu_reg_data = CNTW'(d);
    @(negedge clk);
    cpu_reg_wr = 0;
  endtask

  task automatic mem_acc(input bit we, input int a, input int d, output int rd);
    @(negedge clk);
    cpu_mem_req = 1; cpu_mem_we = we; cpu_mem_addr = AW'(a); cpu_mem_wdata = DW'(d);
    forever begin
      #1;
      if (cpu_mem_gnt) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_mem_req = 0;
    rd = cpu_mem_rdata;
    if (!we) check(cpu_mem_rvalid, "R10 rvalid", cpu_mem_rvalid, 1);
  endtask

  task automatic wait_valid(input int ch);
    int cyc = 0;
    @(negedge clk);
    sie_ch = CHW'(ch);
    #1;
    while (!sie_rvalid && cyc < 40) begin
      @(negedge clk); #1; cyc++;
    end
    check(sie_rvalid && cyc <= BYTE_CLKS, "R2 fetch latency", cyc, BYTE_CLKS);
  endtask

  task automatic take(input int ch, input int cnt);
    @(negedge clk);
    sie_ch = CHW'(ch); #1;
    check(sie_rvalid, "R12 valid before take", sie_rvalid, 1);
    sie_cnt = CNTW'(cnt); sie_in_take = 1;
    @(negedge clk);
    sie_in_take = 0;
  endtask

  task automatic out_byte(input int ch, input int cnt, input int d, input int lim, input int wb);
    @(negedge clk);
    sie_ch = CHW'(ch); sie_cnt = CNTW'(cnt); sie_out_data = DW'(d); sie_out_wr = 1;
    @(negedge clk);
    sie_out_wr = 0;
    if (cnt < lim) ref_mem[(wb + cnt) & 255] = d & 255;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_in(input int ch, input int base, input int n);
    reg_write(0, ch, base);
    wait_valid(ch);
    check(sie_rdata == DW'(ref_mem[base & 255]), "R2 first byte", sie_rdata, ref_mem[base & 255]);
    for (int k = 0; k < n; k++) begin
      check(sie_rdata == DW'(ref_mem[(base + k) & 255]), "R3 stream byte",
            sie_rdata, ref_mem[(base + k) & 255]);
      take(ch, k);
      wait_valid(ch);
    end
    check(sie_rdata == DW'(ref_mem[(base + n) & 255]), "R3 next prefetched",
          sie_rdata, ref_mem[(base + n) & 255]);
  endtask

  task automatic verify_mem(input int a0, input int n, input string req);
    int rd;
    for (int k = 0; k < n; k++) begin
      mem_acc(0, (a0 + k) & 255, 0, rd);
      check(rd == ref_mem[(a0 + k) & 255], req, rd, ref_mem[(a0 + k) & 255]);
    end
  endtask

  task automatic run_out(input int ch, input int wb, input int lim, input int n, input string req);
    reg_write(1, ch, wb);
    reg_write(2, ch, lim);
    for (int k = 0; k < n; k++) out_byte(ch, k, $urandom & 255, lim, wb);
    @(negedge clk);
    cpu_reg_ch = CHW'(ch); #1;
    check(int'(cpu_rx_cnt) == sat_inc(n - 1), "R6 rx count", cpu_rx_cnt, sat_inc(n - 1));
    verify_mem(wb, n + 1, req);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rd;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      sie_ch = CHW'(c); cpu_reg_ch = CHW'(c); #1;
      check(!sie_rvalid, "R1 valid", sie_rvalid, 0);
      check(sie_rdata == 0, "R1 data", sie_rdata, 0);
      check(cpu_rx_cnt == 0, "R1 rx count", cpu_rx_cnt, 0);
    end
    // R10 fill the SRAM from the CPU port
    for (int a = 0; a < 256; a++) begin
      ref_mem[a] = $urandom & 255;
      mem_acc(1, a, ref_mem[a], rd);
    end
    verify_mem(0, 8, "R10 readback");
    // R3 stream across the top of the SRAM
    run_in(1, 253, 6);
    // R11 back-to-back base writes
    @(negedge clk);
    cpu_reg_wr = 1; cpu_reg_sel = 0; cpu_reg_ch = 2; cpu_reg_data = 10;
    @(negedge clk);
    cpu_reg_data = 20;
    @(negedge clk);
    cpu_reg_wr = 0;
    wait_valid(2);
    check(sie_rdata == DW'(ref_mem[20]), "R11 last base wins", sie_rdata, ref_mem[20]);
    // R4 interleaved channels
    reg_write(0, 0, 40);
    reg_write(0, 3, 100);
    for (int k = 0; k < 4; k++) begin
      wait_valid(0);
      check(sie_rdata == DW'(ref_mem[40 + k]), "R4 channel 0", sie_rdata, ref_mem[40 + k]);
      wait_valid(3);
      check(sie_rdata == DW'(ref_mem[100 + k]), "R4 channel 3", sie_rdata, ref_mem[100 + k]);
      take(0, k);
      take(3, k);
    end
    // R5/R6 receive with wrap and drop past limit
    run_out(2, 250, 4, 7, "R5 stored / R6 dropped");
    // R8 resend overwrites
    run_out(2, 250, 4, 3, "R8 overwrite");
    // R7 saturation, limit 0 writes nothing
    reg_write(1, 0, 60);
    reg_write(2, 0, 0);
    out_byte(0, CMAX, 8'h5a, 0, 60);
    @(negedge clk); cpu_reg_ch = 0; #1;
    check(int'(cpu_rx_cnt) == CMAX, "R7 saturate", cpu_rx_cnt, CMAX);
    out_byte(0, CMAX - 1, 8'h5a, 0, 60);
    @(negedge clk); #1;
    check(int'(cpu_rx_cnt) == CMAX, "R7 reach max", cpu_rx_cnt, CMAX);
    verify_mem(60, 1, "R6 limit zero");
    // R9 CPU waits while a prefetch is pending
    @(negedge clk);
    cpu_reg_wr = 1; cpu_reg_sel = 0; cpu_reg_ch = 1; cpu_reg_data = 77;
    @(negedge clk);
    cpu_reg_wr = 0; cpu_mem_req = 1; cpu_mem_we = 0; cpu_mem_addr = 8'd3; #1;
    check(!cpu_mem_gnt, "R9 CPU yields", cpu_mem_gnt, 0);
    cpu_mem_req = 0;
    mem_acc(0, 3, 0, rd);
    check(rd == ref_mem[3], "R9 CPU served later", rd, ref_mem[3]);
    wait_valid(1);
    check(sie_rdata == DW'(ref_mem[77]), "R2 base 77", sie_rdata, ref_mem[77]);
    // random mix
    for (int r = 0; r < 24; r++) begin
      int ch = $urandom_range(NCH - 1);
      int base = $urandom & 255;
      if ($urandom & 1)
        run_in(ch, base, $urandom_range(8, 1));
      else
        run_out(ch, base, $urandom_range(10), $urandom_range(12, 1), "R5 random receive");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule